// File: doc/BRIEF.md
# Register-Register ALU with Condition Flag Update

The block is the execution unit for a compact 16-bit, two-register ALU instruction form. Each cycle it may receive one instruction word together with the two 32-bit operand values, which the register file has already read, and the current N, Z, C and V flags. It decodes the 4-bit operation and the two 3-bit register indices. Then it computes the 32-bit result, decides whether the destination register is written, and produces the next value of each flag with its own update enable.

There are sixteen operations: bitwise logic, four register-amount shifts and rotates, carry-chained add and subtract, negate, three flag-only comparisons and tests, a low-word multiply, bit clear and move-not. Every operation has its own flag rule. The datapath is combinational and feeds one registered output stage, so results follow the input by one clock and a new instruction may be issued every cycle. Flag bits are packed as `[3]`=N, `[2]`=Z, `[1]`=C, `[0]`=V. When an update enable is low, the matching `flags_out` bit equals the incoming flag.

Top module: `rr_alu`

## Requirements
- R1: The instruction fields are: destination/first-operand index in bits [2:0], second-operand index in bits [5:3], operation code in bits [9:6]. When `in_valid` is high at a rising edge, `out_valid`, `rd_idx`, `rs_idx`, `result`, `rd_we`, `flags_out` and `flags_we` show that instruction's outcome after that same edge.
- R2: The operation codes are 0 AND, 1 XOR, C OR, E bit clear (a AND NOT b) and F move-not (NOT b). Each of these writes its result and updates only N and Z.
- R3: Codes 8 (test: a AND b), A (compare: a−b) and B (compare-negative: a+b) never assert `rd_we`. All other codes assert `rd_we` when valid.
- R4: For every operation, when valid, N is updated to result bit 31 and Z is updated to (result == 0).
- R5: Logic operations, test and multiply leave C and V unchanged: their enables stay low and the outputs equal the incoming flags.
- R6: Code 5 (a+b+C) and code B (a+b) set C to the unsigned carry-out and set V to signed overflow.
- R7: Code 6 gives a−b−(1−C), with C set when b+1−C ≤ a. Code A gives a−b, with C set when b ≤ a. Code 9 gives 0−b, with C set only when b is 0. All three set V to signed overflow.
- R8: Code 2 is a logical shift left and code 3 a logical shift right, by op_b[7:0]. For amounts 1..31, C is the last bit shifted out. An amount of 32 gives 0, with C = bit 0 (left shift) or bit 31 (right shift). Amounts above 32 give 0 and clear C.
- R9: Code 4 is an arithmetic shift right by op_b[7:0]. For amounts 1..31, C is the last bit shifted out. Amounts of 32 or more fill every bit with bit 31 and set C to bit 31.
- R10: Code 7 rotates right by op_b[7:0] mod 32, and C takes the new bit 31. A nonzero multiple of 32 returns the operand unchanged and sets C to bit 31.
- R11: For a shift or rotate with op_b[7:0] = 0, the result is op_a and C is not updated. Shifts and rotates never update V.
- R12: Code D writes the low 32 bits of a×b.
- R13: During reset, and after any edge where `in_valid` is low, `out_valid`, `rd_we` and `flags_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 16 | Instruction word |
| op_a | input | 32 | Value of the destination/first-operand register |
| op_b | input | 32 | Value of the second-operand register |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| out_valid | output | 1 | Registered outputs hold a valid instruction's outcome |
| rd_idx | output | 3 | Decoded destination index |
| rs_idx | output | 3 | Decoded second-operand index |
| result | output | 32 | Operation result |
| rd_we | output | 1 | Destination write enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| flags_we | output | 4 | Per-flag update enables {N,Z,C,V} |

## Verification
Every output is produced one register away from the inputs. The outcome of an instruction presented in the cycle before a rising edge is therefore due just after that edge and holds until the next one. The bench drives each instruction on a falling edge and waits for the following rising edge. It compares all outputs 1 ns later against a reference model computed in the bench, and it removes `in_valid` before the next falling edge unless another instruction follows. The idle and reset checks sample the same point after an edge in which `in_valid` was low.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0,
        OP_XOR = 4'h1,
        OP_SHL = 4'h2,
        OP_SHR = 4'h3,
        OP_SAR = 4'h4,
        OP_ADC = 4'h5,
        OP_SBC = 4'h6,
        OP_ROR = 4'h7,
        OP_TST = 4'h8,
        OP_NEG = 4'h9,
        OP_CMP = 4'hA,
        OP_CMN = 4'hB,
        OP_ORR = 4'hC,
        OP_MUL = 4'hD,
        OP_BIC = 4'hE,
        OP_MVN = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2,
        SH_ROT   = 2'd3
    } shift_kind_e;

    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_C = 1;
    localparam int FLG_V = 0;

endpackage

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 8
) (
    input  shift_kind_e         kind,
    input  logic [DATA_W-1:0]   val,
    input  logic [SHAMT_W-1:0]  amt,
    input  logic                c_in,
    output logic [DATA_W-1:0]   res,
    output logic                c_out,
    output logic                c_touch
);
    localparam int LOG_W = $clog2(DATA_W);
    localparam logic [SHAMT_W-1:0] AMT_FULL = SHAMT_W'(DATA_W);

    logic [2*DATA_W-1:0]        wide;
    logic signed [2*DATA_W-1:0] swide;
    logic [LOG_W-1:0]           rot_amt;

    always_comb begin
        wide    = '0;
        swide   = '0;
        rot_amt = amt[LOG_W-1:0];
        res     = val;
        c_out   = c_in;
        c_touch = (amt != '0);
        if (amt != '0) begin
            unique case (kind)
                SH_LEFT: begin
                    if (amt < AMT_FULL) begin
                        wide  = {{DATA_W{1'b0}}, val} << amt;
                        res   = wide[DATA_W-1:0];
                        c_out = wide[DATA_W];
                    end else if (amt == AMT_FULL) begin
                        res   = '0;
                        c_out = val[0];
                    end else begin
                        res   = '0;
                        c_out = 1'b0;
                    end
                end
                SH_RIGHT: begin
                    if (amt < AMT_FULL) begin
                        wide  = {val, {DATA_W{1'b0}}} >> amt;
                        res   = wide[2*DATA_W-1:DATA_W];
                        c_out = wide[DATA_W-1];
                    end else if (amt == AMT_FULL) begin
                        res   = '0;
                        c_out = val[DATA_W-1];
                    end else begin
                        res   = '0;
                        c_out = 1'b0;
                    end
                end
                SH_ARITH: begin
                    if (amt < AMT_FULL) begin
                        swide = $signed({val, {DATA_W{1'b0}}}) >>> amt;
                        res   = swide[2*DATA_W-1:DATA_W];
                        c_out = swide[DATA_W-1];
                    end else begin
                        res   = {DATA_W{val[DATA_W-1]}};
                        c_out = val[DATA_W-1];
                    end
                end
                default: begin
                    if (rot_amt == '0) begin
                        res   = val;
                        c_out = val[DATA_W-1];
                    end else begin
                        wide  = {val, val} >> rot_amt;
                        res   = wide[DATA_W-1:0];
                        c_out = wide[DATA_W-1];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);
    logic [DATA_W-1:0] ovf_vec;

    always_comb begin
        {cout, sum} = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
        ovf_vec     = (x ^ sum) & (y ^ sum);
        ovf         = ovf_vec[DATA_W-1];
    end
endmodule

// File: rtl/rr_alu.sv
module rr_alu
    import alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 3,
    parameter int OP_W    = 4,
    parameter int SHAMT_W = 8,
    parameter int INSTR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  op_a,
    input  logic [DATA_W-1:0]  op_b,
    input  logic [3:0]         flags_in,
    output logic               out_valid,
    output logic [IDX_W-1:0]   rd_idx,
    output logic [IDX_W-1:0]   rs_idx,
    output logic [DATA_W-1:0]  result,
    output logic               rd_we,
    output logic [3:0]         flags_out,
    output logic [3:0]         flags_we
);
    localparam int RD_LSB = 0;
    localparam int RS_LSB = IDX_W;
    localparam int OP_LSB = 2 * IDX_W;
    localparam int OP_MSB = OP_LSB + OP_W;

    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  rd;
        logic [IDX_W-1:0]  rs;
        logic [DATA_W-1:0] res;
        logic              we;
        logic [3:0]        flg;
        logic [3:0]        fwe;
    } stage_t;

    stage_t stage_d, stage_q;

    alu_op_e           op;
    shift_kind_e       sh_kind;
    logic [DATA_W-1:0] sh_res, add_x, add_y, add_sum, prod;
    logic              sh_c, sh_touch, add_cin, add_cout, add_ovf;
    logic              unused_hi;

    assign op        = alu_op_e'(instr[OP_MSB-1:OP_LSB]);
    assign unused_hi = ^instr[INSTR_W-1:OP_MSB];
    assign prod      = op_a * op_b;

    always_comb begin
        unique case (op)
            OP_SHR:  sh_kind = SH_RIGHT;
            OP_SAR:  sh_kind = SH_ARITH;
            OP_ROR:  sh_kind = SH_ROT;
            default: sh_kind = SH_LEFT;
        endcase
        add_x   = op_a;
        add_y   = op_b;
        add_cin = 1'b0;
        unique case (op)
            OP_ADC: add_cin = flags_in[FLG_C];
            OP_SBC: begin add_y = ~op_b; add_cin = flags_in[FLG_C]; end
            OP_CMP: begin add_y = ~op_b; add_cin = 1'b1; end
            OP_NEG: begin add_x = '0; add_y = ~op_b; add_cin = 1'b1; end
            default: ;
        endcase
    end

    alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .kind(sh_kind), .val(op_a), .amt(op_b[SHAMT_W-1:0]),
        .c_in(flags_in[FLG_C]), .res(sh_res), .c_out(sh_c), .c_touch(sh_touch)
    );

    alu_adder #(.DATA_W(DATA_W)) u_adder (
        .x(add_x), .y(add_y), .cin(add_cin),
        .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
    );

    always_comb begin
        stage_d     = '0;
        stage_d.vld = in_valid;
        stage_d.rd  = instr[RS_LSB-1:RD_LSB];
        stage_d.rs  = instr[OP_LSB-1:RS_LSB];
        stage_d.flg = flags_in;
        unique case (op)
            OP_AND, OP_TST: stage_d.res = op_a & op_b;
            OP_XOR:         stage_d.res = op_a ^ op_b;
            OP_ORR:         stage_d.res = op_a | op_b;
            OP_BIC:         stage_d.res = op_a & ~op_b;
            OP_MVN:         stage_d.res = ~op_b;
            OP_MUL:         stage_d.res = prod;
            OP_SHL, OP_SHR, OP_SAR, OP_ROR: begin
                stage_d.res        = sh_res;
                stage_d.flg[FLG_C] = sh_c;
                stage_d.fwe[FLG_C] = sh_touch;
            end
            default: begin
                stage_d.res        = add_sum;
                stage_d.flg[FLG_C] = add_cout;
                stage_d.flg[FLG_V] = add_ovf;
                stage_d.fwe[FLG_C] = 1'b1;
                stage_d.fwe[FLG_V] = 1'b1;
            end
        endcase
        stage_d.flg[FLG_N] = stage_d.res[DATA_W-1];
        stage_d.flg[FLG_Z] = (stage_d.res == '0);
        stage_d.fwe[FLG_N] = 1'b1;
        stage_d.fwe[FLG_Z] = 1'b1;
        stage_d.we = !(op inside {OP_TST, OP_CMP, OP_CMN});
        if (!in_valid) begin
            stage_d.we  = 1'b0;
            stage_d.fwe = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid = stage_q.vld;
    assign rd_idx    = stage_q.rd;
    assign rs_idx    = stage_q.rs;
    assign result    = stage_q.res;
    assign rd_we     = stage_q.we;
    assign flags_out = stage_q.flg;
    assign flags_we  = stage_q.fwe;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    // R3
    no_write_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (instr[OP_MSB-1:OP_LSB] inside {4'h8, 4'hA, 4'hB}) |=> !rd_we);

    // R4
    nz_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> flags_out[FLG_N] == result[DATA_W-1] && flags_out[FLG_Z] == (result == '0));

    // R5
    cv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (instr[OP_MSB-1:OP_LSB] inside {4'h0, 4'h1, 4'h8, 4'hC, 4'hD, 4'hE, 4'hF})
        |=> flags_we[1:0] == 2'b00 && flags_out[1:0] == $past(flags_in[1:0]));

    // R11
    shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (instr[OP_MSB-1:OP_LSB] inside {4'h2, 4'h3, 4'h4, 4'h7}) && op_b[SHAMT_W-1:0] == '0
        |=> result == $past(op_a) && !flags_we[FLG_C] && !flags_we[FLG_V]);

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !rd_we && flags_we == 4'b0000);
endmodule

// File: tb/test_rr_alu.sv
`timescale 1ns/1ps
module test_rr_alu;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] instr;
    logic [31:0] op_a, op_b;
    logic [3:0]  flags_in;
    logic        out_valid;
    logic [2:0]  rd_idx, rs_idx;
    logic [31:0] result;
    logic        rd_we;
    logic [3:0]  flags_out, flags_we;

    int n_chk = 0;
    int n_bad = 0;
    int n_ops = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    rr_alu i_rr_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .op_a(op_a), .op_b(op_b), .flags_in(flags_in),
        .out_valid(out_valid), .rd_idx(rd_idx), .rs_idx(rs_idx), .result(result),
        .rd_we(rd_we), .flags_out(flags_out), .flags_we(flags_we)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic sovf(input longint s);
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [3:0] fin, output logic [31:0] r, output logic we,
                         output logic [3:0] fo, output logic [3:0] fwe);
        logic [63:0] w;
        logic [31:0] v;
        logic        c;
        int          amt;
        fo  = fin;
        fwe = 4'b1100;
        we  = !(op == 4'h8 || op == 4'hA || op == 4'hB);
        r   = '0;
        amt = int'(b[7:0]);
        v   = a;
        c   = fin[1];
        case (op)
            4'h0, 4'h8: r = a & b;
            4'h1: r = a ^ b;
            4'hC: r = a | b;
            4'hE: r = a & ~b;
            4'hF: r = ~b;
            4'hD: begin w = {32'b0, a} * {32'b0, b}; r = w[31:0]; end
            4'h2, 4'h3, 4'h4, 4'h7: begin
                for (int i = 0; i < amt; i++) begin
                    case (op)
                        4'h2: begin c = v[31]; v = {v[30:0], 1'b0}; end
                        4'h3: begin c = v[0];  v = {1'b0, v[31:1]}; end
                        4'h4: begin c = v[0];  v = {v[31], v[31:1]}; end
                        default: begin c = v[0]; v = {v[0], v[31:1]}; end
                    endcase
                end
                r = v;
                if (amt != 0) begin fo[1] = c; fwe[1] = 1'b1; end
            end
            4'h5, 4'hB: begin
                c = (op == 4'h5) ? fin[1] : 1'b0;
                w = {32'b0, a} + {32'b0, b} + {63'b0, c};
                r = w[31:0];
                fo[1] = w[32];
                fo[0] = sovf(longint'($signed(a)) + longint'($signed(b)) + longint'(c));
                fwe[1:0] = 2'b11;
            end
            4'h6: begin
                r = a - b - {31'b0, ~fin[1]};
                fo[1] = ({32'b0, b} + 64'd1 - {63'b0, fin[1]}) <= {32'b0, a};
                fo[0] = sovf(longint'($signed(a)) - longint'($signed(b)) - longint'(~fin[1]));
                fwe[1:0] = 2'b11;
            end
            4'hA: begin
                r = a - b;
                fo[1] = (b <= a);
                fo[0] = sovf(longint'($signed(a)) - longint'($signed(b)));
                fwe[1:0] = 2'b11;
            end
            default: begin
                r = 32'd0 - b;
                fo[1] = (b == 32'd0);
                fo[0] = sovf(-longint'($signed(b)));
                fwe[1:0] = 2'b11;
            end
        endcase
        fo[3] = r[31];
        fo[2] = (r == 32'd0);
    endtask

    task automatic run_op(input string tag, input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [3:0] fin);
        logic [31:0] er;
        logic        ewe;
        logic [3:0]  efo, efwe;
        logic [2:0]  rd, rs;
        rd = 3'(n_ops % 8);
        rs = 3'((n_ops * 3 + 5) % 8);
        n_ops++;
        model(op, a, b, fin, er, ewe, efo, efwe);
        @(negedge clk);
        in_valid = 1'b1;
        instr    = {6'b101010, op, rs, rd};
        op_a     = a;
        op_b     = b;
        flags_in = fin;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        check({tag, " result"}, result, er);
        check({tag, " ctl R1"}, {16'b0, out_valid, rd_idx, rs_idx, rd_we, flags_we, flags_out},
              {16'b0, 1'b1, rd, rs, ewe, efwe, efo});
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b1; instr = 16'h0140; op_a = 32'd1; op_b = 32'd1; flags_in = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        check("R13 reset", {26'b0, out_valid, rd_we, flags_we}, 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_logic;
        run_op("R2 and",  4'h0, 32'hF0F0_1234, 32'h0FF0_FFFF, 4'b0011);
        run_op("R2 xor",  4'h1, 32'hAAAA_5555, 32'hAAAA_5555, 4'b0001);
        run_op("R2 or",   4'hC, 32'h8000_0000, 32'h0000_0001, 4'b0110);
        run_op("R2 bic",  4'hE, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 4'b1010);
        run_op("R2 mvn",  4'hF, 32'h1234_5678, 32'hFFFF_FFFF, 4'b0011);
        run_op("R5 tst",  4'h8, 32'h0000_00F0, 32'h0000_000F, 4'b0011);
    endtask

    task automatic t_add;
        run_op("R6 adc c0",   4'h5, 32'h0000_0001, 32'h0000_0002, 4'b0000);
        run_op("R6 adc c1",   4'h5, 32'hFFFF_FFFF, 32'h0000_0000, 4'b0010);
        run_op("R6 adc ovf",  4'h5, 32'h7FFF_FFFF, 32'h0000_0001, 4'b0000);
        run_op("R6 cmn",      4'hB, 32'h8000_0000, 32'h8000_0000, 4'b0011);
    endtask

    task automatic t_sub;
        run_op("R7 sbc c1",   4'h6, 32'd10, 32'd3, 4'b0010);
        run_op("R7 sbc c0eq", 4'h6, 32'd5,  32'd5, 4'b0000);
        run_op("R7 sbc c0b0", 4'h6, 32'd0,  32'hFFFF_FFFF, 4'b0000);
        run_op("R7 cmp eq",   4'hA, 32'd7,  32'd7, 4'b0000);
        run_op("R7 cmp ovf",  4'hA, 32'h8000_0000, 32'd1, 4'b0000);
        run_op("R7 neg zero", 4'h9, 32'd99, 32'd0, 4'b0001);
        run_op("R7 neg min",  4'h9, 32'd0,  32'h8000_0000, 4'b0000);
        run_op("R7 neg one",  4'h9, 32'd0,  32'd1, 4'b0010);
    endtask

    task automatic t_shift;
        run_op("R8 shl 4",    4'h2, 32'hF000_000F, 32'h0000_0104, 4'b0001);
        run_op("R8 shl 32",   4'h2, 32'h0000_0001, 32'd32, 4'b0000);
        run_op("R8 shl 33",   4'h2, 32'hFFFF_FFFF, 32'd33, 4'b0010);
        run_op("R8 shr 1",    4'h3, 32'h0000_0003, 32'd1, 4'b0000);
        run_op("R8 shr 32",   4'h3, 32'h8000_0000, 32'd32, 4'b0000);
        run_op("R8 shr 200",  4'h3, 32'hFFFF_FFFF, 32'd200, 4'b0010);
        run_op("R9 sar 4",    4'h4, 32'h8000_0010, 32'd4, 4'b0001);
        run_op("R9 sar 31",   4'h4, 32'h4000_0000, 32'd31, 4'b0010);
        run_op("R9 sar 40",   4'h4, 32'h8000_0000, 32'd40, 4'b0000);
        run_op("R9 sar 255",  4'h4, 32'h7FFF_FFFF, 32'd255, 4'b0010);
    endtask

    task automatic t_rotate;
        run_op("R10 ror 8",   4'h7, 32'h1234_5678, 32'd8, 4'b0000);
        run_op("R10 ror 36",  4'h7, 32'h0000_0008, 32'd36, 4'b0000);
        run_op("R10 ror 32",  4'h7, 32'h8000_0001, 32'd32, 4'b0000);
        run_op("R10 ror 64",  4'h7, 32'h7000_0000, 32'd64, 4'b0010);
    endtask

    task automatic t_shift_zero;
        run_op("R11 shl 0",   4'h2, 32'hDEAD_BEEF, 32'hFFFF_FF00, 4'b0011);
        run_op("R11 ror 0",   4'h7, 32'h8000_0000, 32'h0000_0100, 4'b0001);
    endtask

    task automatic t_mul;
        run_op("R12 mul",     4'hD, 32'h0001_0001, 32'h0001_0001, 4'b0011);
        run_op("R12 mul hi",  4'hD, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0010);
        run_op("R12 mul 0",   4'hD, 32'h8000_0000, 32'd2, 4'b0001);
    endtask

    task automatic t_idle;
        @(negedge clk);
        in_valid = 1'b0;
        instr    = 16'h0005;
        @(posedge clk);
        #1;
        check("R13 idle", {26'b0, out_valid, rd_we, flags_we}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_logic();
        t_add();
        t_sub();
        t_shift();
        t_rotate();
        t_shift_zero();
        t_mul();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule